// File: doc/BRIEF.md
# Sticky Interrupt Status with Summary Flags

This block keeps a sticky interrupt status word that collects single-cycle event pulses from around the device. Those sources are the reset-done indication, frame-length and parity errors on the serial link, switch-state changes, two supply-threshold crossings, the temperature warning and shutdown events, over-voltage, under-voltage, a CRC result, wetting and ADC diagnostics, and a check failure. From this word it derives seven summary flags. The serial shifter sends these flags at the start of every read or write frame. The flags have no storage of their own. They always follow the status word, so several sources are folded into one flag by OR.

The word clears only when a frame that read it ends. The serial front end pulses `stat_read_i` when the frame is a read of the status word, and it pulses `cs_rise_i` when chip select goes high. On that rising edge all bits clear, except a bit whose event pulses in the same cycle: that bit stays set. An active-low interrupt output is low whenever any status bit is set.

Top module: `irq_status_agg`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `stat_o` is 14'h0001 (only the reset-done bit 0 set), `flags_o` is 7'h01 and `irq_n_o` is 0.
- R2: A pulse on `ev_pulse_i[k]` sets `stat_o[k]` from the next cycle on, and the bit then stays set until a clear. The bit map is: 0 reset done, 1 frame length error, 2 parity error, 3 switch change, 4 supply threshold A, 5 supply threshold B, 6 temperature warning, 7 temperature shutdown, 8 over-voltage, 9 under-voltage, 10 CRC, 11 wetting diagnostic, 12 ADC diagnostic, 13 check failure.
- R3: A pulse on `temp_clear_i[0]` (warning ended) sets bit 6, and a pulse on `temp_clear_i[1]` (shutdown ended) sets bit 7, in the same way as the onset events.
- R4: `flags_o[0..3]` equal status bits 0..3. `flags_o[4]` is bit 4 OR bit 5. `flags_o[5]` is bit 6 OR bit 7. `flags_o[6]` is the OR of bits 8 to 13.
- R5: `irq_n_o` is 0 exactly when `stat_o` is nonzero.
- R6: If `stat_read_i` pulsed in an earlier cycle since the last chip-select rise, or pulses in the same cycle, a `cs_rise_i` pulse clears all status bits in the next cycle.
- R7: A `cs_rise_i` pulse with no read since the previous chip-select rise leaves `stat_o` unchanged.
- R8: `stat_read_i` alone does not clear. The clear waits for the next `cs_rise_i`, however many cycles later it comes.
- R9: An event that pulses in the same cycle as a clear leaves its bit set after the clear.
- R10: Each chip-select rise consumes the pending read. A second rise without a new read does not clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pulse_i | input | 14 | Single-cycle event pulses, one per status bit |
| temp_clear_i | input | 2 | Temperature event-ended pulses: [0] warning, [1] shutdown |
| stat_read_i | input | 1 | Pulse: the current frame reads the status word |
| cs_rise_i | input | 1 | Pulse: chip select rising edge |
| stat_o | output | 14 | Sticky status word |
| flags_o | output | 7 | Summary flags for the serial header |
| irq_n_o | output | 1 | Active-low interrupt |

## Verification
The assertions assume that every control and event input is synchronous to `clk` and lasts a single cycle per event. They also assume that `stat_read_i` and `cs_rise_i` come from one frame tracker, so a chip-select rise always closes the frame in which any read was flagged. The stimulus changes inputs only on the falling edge and returns them to zero one cycle later, so each pulse is seen by exactly one rising edge. The coincident cases in the vector table are deliberate: a read together with a chip-select rise, and an event together with a clear.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int SRC_W  = 14;
  localparam int FLAG_W = 7;

  // status bit positions
  localparam int B_RST   = 0;
  localparam int B_FRAME = 1;
  localparam int B_PAR   = 2;
  localparam int B_SW    = 3;
  localparam int B_SUPA  = 4;
  localparam int B_SUPB  = 5;
  localparam int B_TW    = 6;
  localparam int B_TSD   = 7;
  localparam int B_OTH_LO = 8;
  localparam int B_OTH_HI = 13;

  // flag positions
  localparam int F_SUP  = 4;
  localparam int F_TEMP = 5;
  localparam int F_OTH  = 6;

  localparam logic [SRC_W-1:0] STAT_RST_VAL = SRC_W'(1) << B_RST;
endpackage

// File: rtl/isr_read_arm.sv
module isr_read_arm (
  input  logic clk,
  input  logic rst,
  input  logic rd_i,
  input  logic cs_rise_i,
  output logic clr_o
);
  logic armed_q;

  assign clr_o = cs_rise_i & (armed_q | rd_i);

  always_ff @(posedge clk) begin
    if (rst)            armed_q <= 1'b0;
    else if (cs_rise_i) armed_q <= 1'b0;
    else if (rd_i)      armed_q <= 1'b1;
  end

  // R10: a chip-select rise always consumes the pending read
  a_r10_arm_consumed: assert property (@(posedge clk) disable iff (rst)
    cs_rise_i |=> !armed_q);

  // R8: a read without a rise keeps the request pending
  a_r8_arm_held: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !cs_rise_i) |=> armed_q);
endmodule

// File: rtl/isr_capture.sv
module isr_capture
  import irq_status_pkg::*;
#(
  parameter int W = SRC_W,
  parameter logic [W-1:0] RST_VAL = STAT_RST_VAL
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o,
  output logic         irq_n_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;
  logic         irq_n_q;

  always_comb begin
    if (clr_i) stat_d = set_i;
    else       stat_d = stat_q | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= RST_VAL;
      irq_n_q <= ~|RST_VAL;
    end else begin
      stat_q  <= stat_d;
      irq_n_q <= ~|stat_d;
    end
  end

  assign stat_o  = stat_q;
  assign irq_n_o = irq_n_q;

  // R2, R9: every pulsed source is set next cycle, even across a clear
  a_r9_event_kept: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((stat_q & $past(set_i)) == $past(set_i)));

  // R6: a clear leaves only the bits pulsed in that cycle
  a_r6_clear_all: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> ((stat_q & ~$past(set_i)) == '0));

  // R7: with no clear and no event the word holds
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && set_i == '0) |=> $stable(stat_q));
endmodule

// File: rtl/isr_flag_map.sv
module isr_flag_map
  import irq_status_pkg::*;
(
  input  logic [SRC_W-1:0]  stat_i,
  output logic [FLAG_W-1:0] flags_o
);
  logic oth;

  always_comb begin
    oth = 1'b0;
    for (int i = B_OTH_LO; i <= B_OTH_HI; i++) oth = oth | stat_i[i];
  end

  genvar g;
  generate
    for (g = 0; g < F_SUP; g++) begin : g_direct
      assign flags_o[g] = stat_i[g];
    end
  endgenerate

  assign flags_o[F_SUP]  = stat_i[B_SUPA] | stat_i[B_SUPB];
  assign flags_o[F_TEMP] = stat_i[B_TW]   | stat_i[B_TSD];
  assign flags_o[F_OTH]  = oth;
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  ev_pulse_i,
  input  logic [1:0]        temp_clear_i,
  input  logic              stat_read_i,
  input  logic              cs_rise_i,
  output logic [SRC_W-1:0]  stat_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_n_o
);
  logic [SRC_W-1:0] set_vec;
  logic             clr;

  // R3: temperature end events share the onset bits
  always_comb begin
    set_vec         = ev_pulse_i;
    set_vec[B_TW]   = ev_pulse_i[B_TW]  | temp_clear_i[0];
    set_vec[B_TSD]  = ev_pulse_i[B_TSD] | temp_clear_i[1];
  end

  isr_read_arm u_arm (
    .clk       (clk),
    .rst       (rst),
    .rd_i      (stat_read_i),
    .cs_rise_i (cs_rise_i),
    .clr_o     (clr)
  );

  isr_capture #(.W(SRC_W), .RST_VAL(STAT_RST_VAL)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .set_i   (set_vec),
    .clr_i   (clr),
    .stat_o  (stat_o),
    .irq_n_o (irq_n_o)
  );

  isr_flag_map u_map (
    .stat_i  (stat_o),
    .flags_o (flags_o)
  );

  // R5: interrupt low exactly when some summary flag is up
  a_r5_irq_matches: assert property (@(posedge clk) disable iff (rst)
    (!irq_n_o) == (flags_o != '0));

  // R4: a set status bit always shows in some flag
  a_r4_flag_cover: assert property (@(posedge clk) disable iff (rst)
    (stat_o != '0) |-> (flags_o != '0));
endmodule

// File: tb/irq_status_agg_bench.sv
module irq_status_agg_bench;
  localparam int CLK_P = 10;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ev = '0;
  logic [1:0]  tc = '0;
  logic        rd = 1'b0;
  logic        cs = 1'b0;
  logic [13:0] stat;
  logic [6:0]  flags;
  logic        irq_n;

  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_status_agg u_irq_status_agg (
    .clk(clk), .rst(rst), .ev_pulse_i(ev), .temp_clear_i(tc),
    .stat_read_i(rd), .cs_rise_i(cs),
    .stat_o(stat), .flags_o(flags), .irq_n_o(irq_n)
  );

  // {req tag, ev, tc, rd, cs, expected stat, expected flags}
  localparam logic [42:0] VEC [NV] = '{
    {4'd6,  14'h0000, 2'b00, 1'b1, 1'b1, 14'h0000, 7'h00}, // R6 read+rise same cycle
    {4'd2,  14'h0008, 2'b00, 1'b0, 1'b0, 14'h0008, 7'h08}, // R2 switch change
    {4'd4,  14'h0010, 2'b00, 1'b0, 1'b0, 14'h0018, 7'h18}, // R4 supply A
    {4'd8,  14'h0000, 2'b00, 1'b1, 1'b0, 14'h0018, 7'h18}, // R8 read alone
    {4'd6,  14'h0000, 2'b00, 1'b0, 1'b1, 14'h0000, 7'h00}, // R6 rise after read
    {4'd3,  14'h0000, 2'b01, 1'b0, 1'b0, 14'h0040, 7'h20}, // R3 warning end
    {4'd4,  14'h0400, 2'b00, 1'b0, 1'b0, 14'h0440, 7'h60}, // R4 CRC -> other
    {4'd10, 14'h0000, 2'b00, 1'b0, 1'b1, 14'h0440, 7'h60}, // R10 rise, no read
    {4'd2,  14'h0006, 2'b00, 1'b1, 1'b0, 14'h0446, 7'h66}, // R2 frame+parity
    {4'd9,  14'h2000, 2'b00, 1'b0, 1'b1, 14'h2000, 7'h40}, // R9 event wins clear
    {4'd9,  14'h0020, 2'b00, 1'b1, 1'b1, 14'h0020, 7'h10}, // R9 supply B with clear
    {4'd6,  14'h0000, 2'b00, 1'b1, 1'b1, 14'h0000, 7'h00}, // R6 clear
    {4'd3,  14'h0001, 2'b10, 1'b0, 1'b0, 14'h0081, 7'h21}, // R3 shutdown end
    {4'd4,  14'h0280, 2'b00, 1'b0, 1'b0, 14'h0281, 7'h61}  // R4 undervolt
  };

  task automatic check(input int tag, input logic [13:0] es, input logic [6:0] ef);
    tests++;
    if (stat !== es) begin
      fails++;
      $display("FAIL R%0d stat got %h exp %h", tag, stat, es);
    end
    tests++;
    if (flags !== ef) begin
      fails++;
      $display("FAIL R%0d flags got %h exp %h", tag, flags, ef);
    end
    tests++;
    if (irq_n !== (es == '0)) begin
      fails++;
      $display("FAIL R5 irq_n got %b exp %b", irq_n, (es == '0));
    end
  endtask

  // apply for one rising edge, sample at the following falling edge
  task automatic cyc(input logic [13:0] e, input logic [1:0] t, input logic r, input logic c);
    @(negedge clk);
    ev = e; tc = t; rd = r; cs = c;
    @(negedge clk);
    ev = '0; tc = '0; rd = 1'b0; cs = 1'b0;
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, 14'h0001, 7'h01);           // R1 during reset
    rst = 1'b0;
    @(negedge clk);
    check(1, 14'h0001, 7'h01);           // R1 after reset release

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][38:25], VEC[i][24:23], VEC[i][22], VEC[i][21]);
      check(int'(VEC[i][42:39]), VEC[i][20:7], VEC[i][6:0]);
    end

    // R8: pending read survives idle cycles, then rise clears
    cyc(14'h0000, 2'b00, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    check(8, 14'h0281, 7'h61);
    cyc(14'h0000, 2'b00, 1'b0, 1'b1);
    check(6, 14'h0000, 7'h00);

    // R7: rise with nothing pending does not clear a fresh event
    cyc(14'h1000, 2'b00, 1'b0, 1'b0);
    cyc(14'h0000, 2'b00, 1'b0, 1'b1);
    check(7, 14'h1000, 7'h40);

    // R1: reset mid-run restores the reset-done bit only
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(1, 14'h0001, 7'h01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule